// File: doc/BRIEF.md
# Scalar Unary Bit-Manipulation Execution Unit

This unit executes one-source scalar instructions for a scalar pipeline. Each valid cycle it takes a 32-bit instruction word, source data that has already been fetched (32 or 64 bits), the current value of the destination, and the current scalar condition bit. One clock later it presents a registered result, a write enable, the destination register number, a width flag for the write, and the next value of the condition bit. An illegal-instruction flag marks any word whose format tag or opcode the unit does not accept.

The operations are move, conditional move, bitwise invert, bit reversal, population counts of zeros and of ones, scans for the first zero or one from the bottom, leading-one and signed leading-bit scans from the top, sign extension from a byte or a halfword, single-bit set and clear in the destination, absolute value, nibble-group fill, and nibble-group compaction. Most of them come in a 32-bit and a 64-bit form. Register indexing, execution-mask updates and program-counter updates are handled elsewhere.

Top module: `sop_unary_alu`

## Requirements
- R1: `out_valid` goes high exactly one clock after a cycle with `in_valid` high and is low one clock after a cycle with `in_valid` low. In an idle cycle `out_we` and `out_illegal` are low, and reset clears every output to zero.
- R2: A word is decoded only when bits 31:23 equal 9'b101111101. The opcode is bits 15:8, and bits 22:16 are returned on `out_dst` one cycle later. A bad tag or an opcode outside 0..27, 40, 41 and 48 sets `out_illegal`, clears `out_we` and `out_data`, and returns `out_scc` equal to the `scc_in` that came with the word.
- R3: Opcodes 0/1 copy the source (32/64 bits), and opcodes 4/5 invert it. Move leaves the condition bit unchanged. Invert sets it to 1 when the result is non-zero and to 0 otherwise. In every 32-bit result bits 63:32 are zero, and `out_wide` is 1 only for opcodes 1, 3, 5, 7, 9, 25, 27 and 41.
- R4: Opcodes 2/3 (conditional move) drive the source with `out_we`=1 when `scc_in` is 1. When `scc_in` is 0 they drive the old destination value with `out_we`=0. The condition bit is not changed.
- R5: Opcodes 8/9 reverse the bit order of the 32-bit or 64-bit source. The condition bit is not changed.
- R6: Opcodes 10/11 count the zero bits and 12/13 count the one bits of the 32-bit or 64-bit source. The result is 32 bits wide, and the condition bit becomes (result != 0).
- R7: Opcodes 14/15 give the index of the lowest zero bit and 16/17 the index of the lowest one bit, or 32'hFFFFFFFF when there is none. The condition bit is not changed.
- R8: Opcodes 18/19 give the number of bits above the highest set bit (0 when the MSB is set), or 32'hFFFFFFFF for a zero source. The condition bit is not changed.
- R9: Opcodes 20/21 give the number of bits above the highest bit that differs from the sign bit, or 32'hFFFFFFFF for all-zero and all-one sources. The condition bit is not changed.
- R10: Opcode 22 sign-extends bits 7:0 and opcode 23 sign-extends bits 15:0 to 32 bits. The condition bit is not changed.
- R11: Opcodes 24/25 clear and 26/27 set one bit of the destination value. The bit index is source bits 4:0 for the 32-bit forms and bits 5:0 for the 64-bit forms. The condition bit is not changed.
- R12: Opcodes 6/7 fill each nibble that has any bit set with 4'b1111 and clear every other nibble. Opcodes 40/41 pack nibble g into result bit g (8 or 16 bits, upper bits zero). For all four, the condition bit becomes (result != 0).
- R13: Opcode 48 gives the 32-bit absolute value, with 32'h80000000 mapping to itself. The condition bit becomes (result != 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction and operands are present this cycle |
| instr | input | 32 | Instruction word |
| src_data | input | 64 | Source operand value (low 32 bits for 32-bit forms) |
| dst_data | input | 64 | Current destination value |
| scc_in | input | 1 | Current scalar condition bit |
| out_valid | output | 1 | Result registers hold a new result |
| out_data | output | 64 | Result value |
| out_dst | output | 7 | Destination register number |
| out_wide | output | 1 | Write covers 64 bits |
| out_we | output | 1 | Destination write enable |
| out_scc | output | 1 | Next scalar condition bit |
| out_illegal | output | 1 | Word not accepted |

## Verification
Every result, including the condition bit, the illegal flag and the destination number, is due in the first clock edge after the cycle in which the word was offered. Nothing is held back longer. The bench drives each word on a falling edge, lets one rising edge pass, and compares all outputs on the following falling edge. It then leaves one idle cycle so that `out_valid` can be seen dropping. The sweep covers every opcode from 0 to 63 plus a few out-of-range ones, with corner and pseudo-random operands and both condition-bit values.

// File: rtl/sop_unary_alu.sv
module sop_unary_alu (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] instr,
  input  logic [63:0] src_data,
  input  logic [63:0] dst_data,
  input  logic        scc_in,
  output logic        out_valid,
  output logic [63:0] out_data,
  output logic [6:0]  out_dst,
  output logic        out_wide,
  output logic        out_we,
  output logic        out_scc,
  output logic        out_illegal
);

  localparam logic [8:0] FMT_TAG = 9'b101111101;
  localparam logic [31:0] NONE = 32'hFFFF_FFFF;

  function automatic logic [31:0] ones_in(input logic [63:0] x, input logic w);
    logic [31:0] c;
    c = '0;
    for (int i = 0; i < 64; i++)
      if (w || i < 32) c = c + {31'd0, x[i]};
    return c;
  endfunction

  function automatic logic [31:0] low_scan(input logic [63:0] x, input logic v, input logic w);
    logic [31:0] r;
    r = NONE;
    for (int i = 63; i >= 0; i--)
      if ((w || i < 32) && x[i] == v) r = 32'(i);
    return r;
  endfunction

  function automatic logic [31:0] high_scan(input logic [63:0] x, input logic v, input logic w);
    logic [31:0] r;
    r = NONE;
    for (int i = 0; i < 64; i++)
      if ((w || i < 32) && x[i] == v) r = w ? 32'(63 - i) : 32'(31 - i);
    return r;
  endfunction

  function automatic logic [63:0] mirror(input logic [63:0] x, input logic w);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < 64; i++)
      if (w) r[i] = x[63-i];
      else if (i < 32) r[i] = x[31-i];
    return r;
  endfunction

  function automatic logic [63:0] nib_fill(input logic [63:0] x, input logic w);
    logic [63:0] r;
    r = '0;
    for (int g = 0; g < 16; g++)
      if (w || g < 8) r[4*g +: 4] = {4{|x[4*g +: 4]}};
    return r;
  endfunction

  function automatic logic [63:0] nib_pack(input logic [63:0] x, input logic w);
    logic [63:0] r;
    r = '0;
    for (int g = 0; g < 16; g++)
      if (w || g < 8) r[g] = |x[4*g +: 4];
    return r;
  endfunction

  logic [7:0]  opc;
  logic        fmt_ok;
  logic [31:0] s32, d32;
  logic [63:0] res;
  logic        legal, wide, we, sets_scc;

  assign opc    = instr[15:8];
  assign fmt_ok = instr[31:23] == FMT_TAG;
  assign s32    = src_data[31:0];
  assign d32    = dst_data[31:0];

  always_comb begin
    res      = '0;
    legal    = 1'b1;
    wide     = 1'b0;
    we       = 1'b1;
    sets_scc = 1'b0;
    case (opc)
      8'd0:  res = {32'd0, s32};
      8'd1:  begin res = src_data; wide = 1'b1; end
      8'd2:  begin res = {32'd0, scc_in ? s32 : d32}; we = scc_in; end
      8'd3:  begin res = scc_in ? src_data : dst_data; we = scc_in; wide = 1'b1; end
      8'd4:  begin res = {32'd0, ~s32}; sets_scc = 1'b1; end
      8'd5:  begin res = ~src_data; sets_scc = 1'b1; wide = 1'b1; end
      8'd6:  begin res = nib_fill(src_data, 1'b0); sets_scc = 1'b1; end
      8'd7:  begin res = nib_fill(src_data, 1'b1); sets_scc = 1'b1; wide = 1'b1; end
      8'd8:  res = mirror(src_data, 1'b0);
      8'd9:  begin res = mirror(src_data, 1'b1); wide = 1'b1; end
      8'd10: begin res = {32'd0, ones_in(~src_data, 1'b0)}; sets_scc = 1'b1; end
      8'd11: begin res = {32'd0, ones_in(~src_data, 1'b1)}; sets_scc = 1'b1; end
      8'd12: begin res = {32'd0, ones_in(src_data, 1'b0)}; sets_scc = 1'b1; end
      8'd13: begin res = {32'd0, ones_in(src_data, 1'b1)}; sets_scc = 1'b1; end
      8'd14: res = {32'd0, low_scan(src_data, 1'b0, 1'b0)};
      8'd15: res = {32'd0, low_scan(src_data, 1'b0, 1'b1)};
      8'd16: res = {32'd0, low_scan(src_data, 1'b1, 1'b0)};
      8'd17: res = {32'd0, low_scan(src_data, 1'b1, 1'b1)};
      8'd18: res = {32'd0, high_scan(src_data, 1'b1, 1'b0)};
      8'd19: res = {32'd0, high_scan(src_data, 1'b1, 1'b1)};
      8'd20: res = {32'd0, high_scan(src_data, ~src_data[31], 1'b0)};
      8'd21: res = {32'd0, high_scan(src_data, ~src_data[63], 1'b1)};
      8'd22: res = {32'd0, {24{s32[7]}}, s32[7:0]};
      8'd23: res = {32'd0, {16{s32[15]}}, s32[15:0]};
      8'd24: res = {32'd0, d32 & ~(32'd1 << src_data[4:0])};
      8'd25: begin res = dst_data & ~(64'd1 << src_data[5:0]); wide = 1'b1; end
      8'd26: res = {32'd0, d32 | (32'd1 << src_data[4:0])};
      8'd27: begin res = dst_data | (64'd1 << src_data[5:0]); wide = 1'b1; end
      8'd40: begin res = nib_pack(src_data, 1'b0); sets_scc = 1'b1; end
      8'd41: begin res = nib_pack(src_data, 1'b1); sets_scc = 1'b1; wide = 1'b1; end
      8'd48: begin res = {32'd0, s32[31] ? (~s32 + 32'd1) : s32}; sets_scc = 1'b1; end
      default: legal = 1'b0;
    endcase
    if (!fmt_ok) legal = 1'b0;
    if (!legal) begin
      res      = '0;
      wide     = 1'b0;
      we       = 1'b0;
      sets_scc = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_dst     <= '0;
      out_wide    <= 1'b0;
      out_we      <= 1'b0;
      out_scc     <= 1'b0;
      out_illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data    <= res;
        out_dst     <= instr[22:16];
        out_wide    <= wide;
        out_we      <= we;
        out_scc     <= sets_scc ? (res != 64'd0) : scc_in;
        out_illegal <= !legal;
      end else begin
        out_we      <= 1'b0;
        out_illegal <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sop_unary_alu_chk.sv
module sop_unary_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] instr,
  input logic [63:0] src_data,
  input logic [63:0] dst_data,
  input logic        scc_in,
  input logic        out_valid,
  input logic [63:0] out_data,
  input logic [6:0]  out_dst,
  input logic        out_wide,
  input logic        out_we,
  input logic        out_scc,
  input logic        out_illegal
);

  logic fmt_good;
  assign fmt_good = instr[31:23] == 9'b101111101;

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_we && !out_illegal));

  assert_bad_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !fmt_good) |=> (out_illegal && !out_we && out_scc == $past(scc_in)));

  assert_dst_forward_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_dst == $past(instr[22:16]));

  assert_move_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt_good && instr[15:8] == 8'd0) |=>
      (out_we && !out_wide && out_data == {32'd0, $past(src_data[31:0])} && out_scc == $past(scc_in)));

  assert_cmov_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt_good && instr[15:8] == 8'd3 && !scc_in) |=>
      (!out_we && out_data == $past(dst_data) && !out_scc));

  assert_popcount_scc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt_good && instr[15:8] == 8'd13) |=>
      (out_data == 64'($countones($past(src_data))) && out_scc == ($past(src_data) != 64'd0)));

endmodule

bind sop_unary_alu sop_unary_alu_chk chk_i (.*);

// File: tb/sop_unary_alu_tb_top.sv
`timescale 1ns/1ps
module sop_unary_alu_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] src_data = '0;
  logic [63:0] dst_data = '0;
  logic        scc_in = 1'b0;
  logic        out_valid, out_wide, out_we, out_scc, out_illegal;
  logic [63:0] out_data;
  logic [6:0]  out_dst;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sop_unary_alu dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .src_data(src_data), .dst_data(dst_data), .scc_in(scc_in),
    .out_valid(out_valid), .out_data(out_data), .out_dst(out_dst),
    .out_wide(out_wide), .out_we(out_we), .out_scc(out_scc),
    .out_illegal(out_illegal)
  );

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h (instr %h src %h dst %h scc %b)",
               tag, what, act, exp, instr, src_data, dst_data, scc_in);
    end
  endtask

  function automatic string tag_of(input logic [7:0] op);
    case (op)
      8'd0, 8'd1, 8'd4, 8'd5:          return "R3";
      8'd2, 8'd3:                      return "R4";
      8'd8, 8'd9:                      return "R5";
      8'd10, 8'd11, 8'd12, 8'd13:      return "R6";
      8'd14, 8'd15, 8'd16, 8'd17:      return "R7";
      8'd18, 8'd19:                    return "R8";
      8'd20, 8'd21:                    return "R9";
      8'd22, 8'd23:                    return "R10";
      8'd24, 8'd25, 8'd26, 8'd27:      return "R11";
      8'd6, 8'd7, 8'd40, 8'd41:        return "R12";
      8'd48:                           return "R13";
      default:                         return "R2";
    endcase
  endfunction

  task automatic model(input logic [31:0] ins, input logic [63:0] s, input logic [63:0] d, input logic sc,
                       output logic [63:0] r, output logic w, output logic c,
                       output logic il, output logic wd);
    logic [7:0] op;
    int n, k;
    logic [63:0] m, t;
    logic nz_rule;
    op = ins[15:8];
    n = op[0] ? 64 : 32;
    m = (n == 64) ? '1 : 64'h0000_0000_FFFF_FFFF;
    r = '0; w = 1'b1; il = 1'b0; nz_rule = 1'b0;
    wd = (op inside {8'd1, 8'd3, 8'd5, 8'd7, 8'd9, 8'd25, 8'd27, 8'd41});
    case (op)
      8'd0, 8'd1: r = s & m;
      8'd2, 8'd3: begin r = (sc ? s : d) & m; w = sc; end
      8'd4, 8'd5: begin r = ~s & m; nz_rule = 1'b1; end
      8'd6, 8'd7: begin
        for (int g = 0; g < n / 4; g++) if (((s >> (4 * g)) & 64'hF) != 0) r = r | (64'hF << (4 * g));
        nz_rule = 1'b1;
      end
      8'd8:  r = {32'd0, {<<{s[31:0]}}};
      8'd9:  r = {<<{s}};
      8'd10, 8'd11: begin r = 64'(n - $countones(s & m)); nz_rule = 1'b1; end
      8'd12, 8'd13: begin r = 64'($countones(s & m)); nz_rule = 1'b1; end
      8'd14, 8'd15, 8'd16, 8'd17: begin
        k = 0;
        while (k < n && s[k] != (op >= 8'd16)) k++;
        r = (k == n) ? 64'h0000_0000_FFFF_FFFF : 64'(k);
      end
      8'd18, 8'd19, 8'd20, 8'd21: begin
        k = n - 1;
        while (k >= 0 && s[k] != ((op >= 8'd20) ? ~s[n-1] : 1'b1)) k--;
        r = (k < 0) ? 64'h0000_0000_FFFF_FFFF : 64'(n - 1 - k);
      end
      8'd22: r = {32'd0, 32'($signed(s[7:0]))};
      8'd23: r = {32'd0, 32'($signed(s[15:0]))};
      8'd24, 8'd25, 8'd26, 8'd27: begin
        t = d & m;
        t[(n == 64) ? int'(s[5:0]) : int'(s[4:0])] = (op >= 8'd26);
        r = t;
      end
      8'd40, 8'd41: begin
        for (int g = 0; g < n / 4; g++) r[g] = ((s >> (4 * g)) & 64'hF) != 0;
        nz_rule = 1'b1;
      end
      8'd48: begin
        r = {32'd0, ($signed(s[31:0]) < 0) ? 32'(-$signed(s[31:0])) : s[31:0]};
        nz_rule = 1'b1;
      end
      default: il = 1'b1;
    endcase
    if (ins[31:23] != 9'b101111101) il = 1'b1;
    if (il) begin r = '0; w = 1'b0; wd = 1'b0; nz_rule = 1'b0; end
    c = nz_rule ? (r != 0) : sc;
  endtask

  task automatic run(input logic [31:0] ins, input logic [63:0] s, input logic [63:0] d, input logic sc);
    logic [63:0] er;
    logic ew, ec, ei, ewd;
    string tg;
    model(ins, s, d, sc, er, ew, ec, ei, ewd);
    tg = (ins[31:23] != 9'b101111101) ? "R2" : tag_of(ins[15:8]);
    @(negedge clk);
    instr = ins; src_data = s; dst_data = d; scc_in = sc; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1", "out_valid", 64'(out_valid), 64'd1);
    check(tg, "out_data", out_data, er);
    check(tg, "out_we", 64'(out_we), 64'(ew));
    check(tg, "out_scc", 64'(out_scc), 64'(ec));
    check(tg, "out_illegal", 64'(out_illegal), 64'(ei));
    check(tg, "out_wide", 64'(out_wide), 64'(ewd));
    check("R2", "out_dst", 64'(out_dst), 64'(ins[22:16]));
  endtask

  function automatic logic [31:0] mk(input logic [8:0] tag, input logic [6:0] dst, input logic [7:0] op);
    return {tag, dst, op, 8'h5A};
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [63:0] pat [24];
    logic [63:0] lcg;
    logic [63:0] dv;
    lcg = 64'h1234_5678_9ABC_DEF1;
    pat[0] = 64'd0;                  pat[1] = '1;
    pat[2] = 64'd1;                  pat[3] = 64'h8000_0000_0000_0000;
    pat[4] = 64'h0000_0000_8000_0000; pat[5] = 64'hFFFF_FFFF_7FFF_FFFF;
    pat[6] = 64'h0000_0000_FFFF_FFFF; pat[7] = 64'hFFFF_FFFF_0000_0000;
    pat[8] = 64'h0000_0000_0000_0010; pat[9] = 64'h0000_0000_0000_003F;
    pat[10] = 64'h0000_0000_0000_001F; pat[11] = 64'h4000_0000_0F00_00F0;
    for (int i = 12; i < 24; i++) begin
      lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
      pat[i] = lcg;
    end

    repeat (3) @(negedge clk);
    check("R1", "reset out_valid", 64'(out_valid), 64'd0);
    check("R1", "reset out_data", out_data, 64'd0);
    check("R1", "reset out_we", 64'(out_we), 64'd0);
    check("R1", "reset out_scc", 64'(out_scc), 64'd0);
    rst_n = 1'b1;

    for (int op = 0; op < 64; op++) begin
      for (int p = 0; p < 24; p++) begin
        for (int sc = 0; sc < 2; sc++) begin
          lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
          dv = (p % 3 == 0) ? pat[(p + 5) % 24] : lcg;
          run(mk(9'b101111101, 7'(p + op), 8'(op)), pat[p], dv, sc[0]);
        end
      end
      @(negedge clk);
      check("R1", "idle out_valid", 64'(out_valid), 64'd0);
      check("R1", "idle out_we", 64'(out_we), 64'd0);
    end

    run(mk(9'b101111101, 7'd9, 8'd200), pat[3], pat[4], 1'b1);
    run(mk(9'b101111101, 7'd9, 8'd255), pat[3], pat[4], 1'b0);
    run(mk(9'b101111100, 7'd1, 8'd0), pat[6], pat[1], 1'b1);
    run(mk(9'b000000000, 7'd2, 8'd4), pat[0], pat[1], 1'b0);
    run(mk(9'b111111111, 7'd3, 8'd48), pat[4], pat[1], 1'b1);
    run(mk(9'b001111101, 7'd4, 8'd12), pat[1], pat[2], 1'b0);
    run(mk(9'b101111101, 7'd127, 8'd48), 64'h0000_0000_8000_0000, '0, 1'b0);
    run(mk(9'b101111101, 7'd64, 8'd48), 64'h0000_0000_FFFF_FFFF, '0, 1'b0);
    run(mk(9'b101111101, 7'd5, 8'd26), 64'h0000_0000_0000_003F, '0, 1'b0);
    run(mk(9'b101111101, 7'd6, 8'd27), 64'h0000_0000_0000_007F, '0, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule